// File: doc/BRIEF.md
# SECDED Protected Quadword Memory Wrapper

This block sits between a requester and a 72-bit synchronous memory array. Every 64-bit quadword is stored with 8 check bits of an extended Hamming code. On the way in the check bits are generated. On the way out they are regenerated and compared with the stored ones. A single flipped bit is repaired in the returned data, and a double flip is flagged as uncorrectable.

The requester issues a command with a start address, a direction and a burst length of 1 to 16 quadwords. Addresses advance by one quadword per beat. Read beats come back one per cycle on a response port. Write beats arrive on a data channel with a per-byte enable mask. A beat with all eight bytes enabled is encoded and written at once. Any other mask starts a read-modify-write for that quadword: the old word is read and corrected, the enabled bytes are replaced, and the result is re-encoded and written back. If the old word holds an uncorrectable error, the write of that quadword is dropped. A sticky error flag then records the address.

Top module: `ecc_mem_wrap`

## Requirements
- R1: Bits [63:0] of a stored word hold the data quadword unchanged. Bits [71:64] hold the check byte. The check byte makes the XOR of all 72 stored bits zero. Writing a quadword and reading it back returns the same data with rsp_fixed=0 and rsp_bad=0.
- R2: If exactly one of the 72 stored bits is flipped, whether data, Hamming check bit or overall parity bit, a read returns the original data with rsp_fixed=1 and rsp_bad=0.
- R3: If exactly two stored bits are flipped, a read returns rsp_bad=1 and rsp_fixed=0. err_sticky becomes 1 and err_addr takes that quadword's address.
- R4: The first read beat appears on the response port two rising edges after the edge that accepts the command. The following beats come on consecutive cycles.
- R5: cmd_len holds the beat count minus one, so a command covers 1 to 16 quadwords. Beat i uses address cmd_addr+i. Exactly that many read responses or write beats occur.
- R6: A write beat with wd_mask=8'hFF is written to memory at the edge that accepts it, with no memory read.
- R7: A write beat with any other mask reads the old quadword at its accept edge. It then writes at the next edge, with byte b taken from wd_data where wd_mask[b]=1 and from the corrected old data elsewhere. wd_ready is low during that merge cycle.
- R8: If the old quadword of a read-modify-write is uncorrectable, that memory word is left unchanged. err_sticky is set and err_addr takes its address. The rest of the burst continues.
- R9: err_sticky stays 1 until reset. err_addr holds the address of the most recent uncorrectable error.
- R10: During and after reset, cmd_ready=1, wd_ready=0, rsp_valid=0, mem_en=0 and err_sticky=0.
- R11: cmd_ready is high only when no command is in progress. wd_ready is high only while a write command waits for a beat, and never together with cmd_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_write | input | 1 | 1 for a write burst, 0 for a read burst |
| cmd_addr | input | AW | Quadword start address |
| cmd_len | input | LW | Beat count minus one |
| wd_valid | input | 1 | Write beat offered |
| wd_ready | output | 1 | Write beat accepted when high with wd_valid |
| wd_data | input | 64 | Write quadword |
| wd_mask | input | 8 | Byte enables, bit b for byte b |
| rsp_valid | output | 1 | Read beat valid |
| rsp_data | output | 64 | Corrected read quadword |
| rsp_fixed | output | 1 | A single-bit error was repaired in this beat |
| rsp_bad | output | 1 | This beat holds an uncorrectable error |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write when high with mem_en |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 72 | Encoded word to store |
| mem_rdata | input | 72 | Stored word, valid the cycle after a read strobe |
| err_sticky | output | 1 | Uncorrectable error seen since reset |
| err_addr | output | AW | Address of the latest uncorrectable error |

## Verification
All inputs are driven and all outputs are sampled on falling edges, and the bench counts rising edges from the command-acceptance edge. The response port is silent on the first and second falling edges after acceptance and carries beat i on falling edge 3+i. It must fall silent again right after the last beat. A full-mask write is in the memory model after its acceptance edge. A partial-mask write lands one edge later, and the bench confirms this by reading back and by counting memory reads and writes across each write command. Error injection flips bits in the bench's memory array between commands, so corrected data and flags are predicted from the written values alone.

// File: rtl/ecc_pkg.sv
// Package: shared constants, the controller state type and the SECDED code
// functions. Assumes a 64-bit quadword with 7 Hamming bits placed at the
// power-of-two positions 1..64 of a 71-position codeword, plus one overall
// parity bit stored in bit 71 of the memory word.
package ecc_pkg;

    localparam int DW = 64;           // data bits per quadword
    localparam int HW = 7;            // Hamming check bits
    localparam int CW = HW + 1;       // stored check bits
    localparam int WW = DW + CW;      // stored word width
    localparam int NB = DW / 8;       // bytes per quadword
    localparam int LASTPOS = DW + HW; // highest codeword position

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WDATA = 2'd2,
        ST_MERGE = 2'd3
    } ctl_state_t;

    // Codeword position of data bit idx: the idx-th non-power-of-two position.
    function automatic int ecc_pos(input int idx);
        int k;
        int r;
        k = 0;
        r = 0;
        for (int p = 1; p <= LASTPOS; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (k == idx) r = p;
                k++;
            end
        end
        return r;
    endfunction

    // Check byte: Hamming bits are the XOR of positions of set data bits,
    // the top bit makes the whole stored word even in parity.
    function automatic logic [CW-1:0] ecc_gen(input logic [DW-1:0] d);
        logic [HW-1:0] c;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p <= LASTPOS; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (d[k[5:0]]) c = c ^ p[HW-1:0];
                k++;
            end
        end
        return {^{d, c}, c};
    endfunction

endpackage

// File: rtl/ecc_encode.sv
// Module: ecc_encode
// Purpose: forms the 72-bit stored word from a 64-bit quadword.
// Assumes: purely combinational; layout is {check byte, data}.
module ecc_encode
    import ecc_pkg::*;
(
    input  logic [DW-1:0] data_in,
    output logic [WW-1:0] word_out
);

    // Append the generated check byte above the unchanged data.
    always_comb begin
        word_out = {ecc_gen(data_in), data_in};
    end

endmodule

// File: rtl/ecc_decode.sv
// Module: ecc_decode
// Purpose: checks a stored word, repairs one flipped bit and classifies it.
// Assumes: combinational; word layout as produced by ecc_encode. A nonzero
// syndrome with even overall parity, or a syndrome pointing past the last
// codeword position, is treated as uncorrectable.
module ecc_decode
    import ecc_pkg::*;
(
    input  logic [WW-1:0] word_in,
    output logic [DW-1:0] data_out,
    output logic          err_single,
    output logic          err_double
);

    logic [CW-1:0] regen;
    logic [HW-1:0] syn;
    logic          par_odd;
    logic          syn_zero;
    logic          syn_range;
    logic [DW-1:0] flip;

    // Regenerate the check byte from the fetched data.
    always_comb begin
        regen = ecc_gen(word_in[DW-1:0]);
    end

    // Syndrome and overall parity of the stored word.
    always_comb begin
        syn       = regen[HW-1:0] ^ word_in[DW+HW-1:DW];
        par_odd   = ^word_in;
        syn_zero  = (syn == '0);
        syn_range = (int'(syn) <= LASTPOS);
    end

    // Classify the error from syndrome and parity.
    always_comb begin
        err_single = par_odd && syn_range;
        err_double = (!par_odd && !syn_zero) || (par_odd && !syn_range);
    end

    // One flip enable per data bit, matched against its codeword position.
    for (genvar i = 0; i < DW; i++) begin : g_fix
        localparam int POS = ecc_pos(i);
        assign flip[i] = err_single && (syn == POS[HW-1:0]);
    end

    // Repaired data out.
    always_comb begin
        data_out = word_in[DW-1:0] ^ flip;
    end

endmodule

// File: rtl/ecc_byte_merge.sv
// Module: ecc_byte_merge
// Purpose: combines new bytes into an old quadword under a byte mask.
// Assumes: mask bit b selects byte b of the new quadword.
module ecc_byte_merge
    import ecc_pkg::*;
(
    input  logic [DW-1:0] old_data,
    input  logic [DW-1:0] new_data,
    input  logic [NB-1:0] byte_en,
    output logic [DW-1:0] merged
);

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign merged[8*b +: 8] = byte_en[b] ? new_data[8*b +: 8] : old_data[8*b +: 8];
    end

endmodule

// File: rtl/ecc_burst_ctrl.sv
// Module: ecc_burst_ctrl
// Purpose: walks a burst one quadword at a time and drives the memory strobes.
// Assumes: memory reads return data in the cycle after the strobe; a partial
// beat takes two cycles (read, then merge-write), a full beat takes one.
module ecc_burst_ctrl
    import ecc_pkg::*;
#(
    parameter int AW = 10,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [LW-1:0] cmd_len,
    output logic          cmd_ready,
    input  logic          wd_valid,
    input  logic          wd_full,
    output logic          wd_ready,
    input  logic          rmw_bad,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic          sel_merge,
    output logic          hold_load,
    output logic          rd_issue,
    output logic          rmw_abort
);

    ctl_state_t    st_q, st_d;
    logic [AW-1:0] addr_q, addr_d;
    logic [LW-1:0] left_q, left_d;
    logic          step;

    // State, current address and remaining beat count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            left_q <= '0;
        end else begin
            st_q   <= st_d;
            addr_q <= addr_d;
            left_q <= left_d;
        end
    end

    // Next-state logic and per-state strobes.
    always_comb begin
        st_d      = st_q;
        addr_d    = addr_q;
        left_d    = left_q;
        cmd_ready = 1'b0;
        wd_ready  = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        sel_merge = 1'b0;
        hold_load = 1'b0;
        rmw_abort = 1'b0;
        step      = 1'b0;
        case (st_q)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    addr_d = cmd_addr;
                    left_d = cmd_len;
                    st_d   = cmd_write ? ST_WDATA : ST_READ;
                end
            end
            ST_READ: begin
                mem_en = 1'b1;
                step   = 1'b1;
            end
            ST_WDATA: begin
                wd_ready = 1'b1;
                if (wd_valid) begin
                    mem_en = 1'b1;
                    if (wd_full) begin
                        mem_we = 1'b1;
                        step   = 1'b1;
                    end else begin
                        hold_load = 1'b1;
                        st_d      = ST_MERGE;
                    end
                end
            end
            ST_MERGE: begin
                sel_merge = 1'b1;
                mem_en    = !rmw_bad;
                mem_we    = !rmw_bad;
                rmw_abort = rmw_bad;
                step      = 1'b1;
            end
            default: st_d = ST_IDLE;
        endcase
        if (step) begin
            if (left_q == '0) begin
                st_d = ST_IDLE;
            end else begin
                addr_d = addr_q + AW'(1);
                left_d = left_q - LW'(1);
                if (st_q != ST_READ) st_d = ST_WDATA;
            end
        end
    end

    // Address and read-issue indication to the datapath.
    always_comb begin
        mem_addr = addr_q;
        rd_issue = (st_q == ST_READ);
    end

endmodule

// File: rtl/ecc_mem_wrap.sv
// Module: ecc_mem_wrap
// Purpose: SECDED-protected burst access to a 72-bit synchronous memory,
// with byte-masked writes turned into read-modify-write sequences.
// Assumes: the memory returns read data one cycle after mem_en with mem_we
// low; responses cannot be stalled; err_sticky clears only on reset.
module ecc_mem_wrap
    import ecc_pkg::*;
#(
    parameter int AW        = 10,
    parameter int MAX_BURST = 16,
    parameter int LW        = $clog2(MAX_BURST)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [LW-1:0] cmd_len,
    input  logic          wd_valid,
    output logic          wd_ready,
    input  logic [63:0]   wd_data,
    input  logic [7:0]    wd_mask,
    output logic          rsp_valid,
    output logic [63:0]   rsp_data,
    output logic          rsp_fixed,
    output logic          rsp_bad,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [71:0]   mem_wdata,
    input  logic [71:0]   mem_rdata,
    output logic          err_sticky,
    output logic [AW-1:0] err_addr
);

    logic          wd_full;
    logic          sel_merge;
    logic          hold_load;
    logic          rd_issue;
    logic          rmw_abort;
    logic          dec_single;
    logic          dec_double;
    logic [DW-1:0] dec_data;
    logic [DW-1:0] merged;
    logic [DW-1:0] enc_in;
    logic [DW-1:0] hold_data;
    logic [NB-1:0] hold_mask;
    logic          rd_pend_q;
    logic [AW-1:0] rd_addr_q;

    // A beat with every byte enabled skips the read phase.
    always_comb begin
        wd_full = (wd_mask == '1);
    end

    ecc_burst_ctrl #(
        .AW (AW),
        .LW (LW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_len   (cmd_len),
        .cmd_ready (cmd_ready),
        .wd_valid  (wd_valid),
        .wd_full   (wd_full),
        .wd_ready  (wd_ready),
        .rmw_bad   (dec_double),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .sel_merge (sel_merge),
        .hold_load (hold_load),
        .rd_issue  (rd_issue),
        .rmw_abort (rmw_abort)
    );

    ecc_decode u_dec (
        .word_in    (mem_rdata),
        .data_out   (dec_data),
        .err_single (dec_single),
        .err_double (dec_double)
    );

    ecc_byte_merge u_merge (
        .old_data (dec_data),
        .new_data (hold_data),
        .byte_en  (hold_mask),
        .merged   (merged)
    );

    // Encoder source: merged word in the merge cycle, fresh beat otherwise.
    always_comb begin
        enc_in = sel_merge ? merged : wd_data;
    end

    ecc_encode u_enc (
        .data_in  (enc_in),
        .word_out (mem_wdata)
    );

    // Hold a partial beat while its old quadword is fetched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_mask <= '0;
        end else if (hold_load) begin
            hold_data <= wd_data;
            hold_mask <= wd_mask;
        end
    end

    // Track which cycle's memory data belongs to a read burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend_q <= 1'b0;
            rd_addr_q <= '0;
        end else begin
            rd_pend_q <= rd_issue;
            rd_addr_q <= mem_addr;
        end
    end

    // Register the corrected read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_fixed <= 1'b0;
            rsp_bad   <= 1'b0;
        end else begin
            rsp_valid <= rd_pend_q;
            rsp_data  <= dec_data;
            rsp_fixed <= rd_pend_q && dec_single;
            rsp_bad   <= rd_pend_q && dec_double;
        end
    end

    // Sticky record of the latest uncorrectable error address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_sticky <= 1'b0;
            err_addr   <= '0;
        end else if (rd_pend_q && dec_double) begin
            err_sticky <= 1'b1;
            err_addr   <= rd_addr_q;
        end else if (rmw_abort) begin
            err_sticky <= 1'b1;
            err_addr   <= mem_addr;
        end
    end

endmodule

// File: rtl/ecc_mem_wrap_chk.sv
// Module: ecc_mem_wrap_chk
// Purpose: temporal properties of the wrapper ports, attached by bind.
// Assumes: same clock and synchronous active-low reset as the wrapper.
module ecc_mem_wrap_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_ready,
    input logic       wd_valid,
    input logic       wd_ready,
    input logic [7:0] wd_mask,
    input logic       rsp_valid,
    input logic       rsp_fixed,
    input logic       rsp_bad,
    input logic       mem_en,
    input logic       mem_we,
    input logic       err_sticky
);

    // R6: a full-mask beat is written at its accept edge
    a_r6_full_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_valid && wd_ready && wd_mask == 8'hFF) |-> (mem_en && mem_we));

    // R7: a partial beat first reads the old word
    a_r7_partial_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_valid && wd_ready && wd_mask != 8'hFF) |-> (mem_en && !mem_we));

    // R7: no beat is taken during the merge cycle
    a_r7_merge_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_valid && wd_ready && wd_mask != 8'hFF) |=> !wd_ready);

    // R4: each response follows a memory read two cycles earlier
    a_r4_rsp_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(mem_en && !mem_we, 2));

    // R3: a beat is never both repaired and uncorrectable
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_fixed && rsp_bad));

    // R2: error flags only accompany a valid response
    a_r2_flags_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fixed || rsp_bad) |-> rsp_valid);

    // R9: the sticky flag never drops outside reset
    a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    // R11: command and data channels are never ready together
    a_r11_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ready && wd_ready));

endmodule

bind ecc_mem_wrap ecc_mem_wrap_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_ready  (cmd_ready),
    .wd_valid   (wd_valid),
    .wd_ready   (wd_ready),
    .wd_mask    (wd_mask),
    .rsp_valid  (rsp_valid),
    .rsp_fixed  (rsp_fixed),
    .rsp_bad    (rsp_bad),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .err_sticky (err_sticky)
);

// File: tb/ecc_mem_wrap_bench.sv
`timescale 1ns/1ps
module ecc_mem_wrap_bench;

    localparam int AW = 10;
    localparam int LW = 4;

    typedef struct packed {
        logic [5:0]  addr;
        logic [63:0] old_q;
        logic [63:0] new_q;
        logic [7:0]  mask;
    } vec_t;

    localparam vec_t VEC [0:5] = '{
        '{6'd1, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 8'hFF},
        '{6'd2, 64'hFFFF_0000_FFFF_0000, 64'h1111_2222_3333_4444, 8'h00},
        '{6'd3, 64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_0000_00AA, 8'h01},
        '{6'd4, 64'h0000_0000_0000_0000, 64'h7700_0000_0000_0000, 8'h80},
        '{6'd5, 64'hA5A5_A5A5_5A5A_5A5A, 64'h0F0F_F0F0_3C3C_C3C3, 8'h5A},
        '{6'd6, 64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 8'hF0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic          cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic          wd_valid = 1'b0;
    logic          wd_ready;
    logic [63:0]   wd_data = '0;
    logic [7:0]    wd_mask = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_data;
    logic          rsp_fixed;
    logic          rsp_bad;
    logic          mem_en;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [71:0]   mem_wdata;
    logic [71:0]   mem_rdata = '0;
    logic          err_sticky;
    logic [AW-1:0] err_addr;

    logic [71:0] mem [0:63];
    logic [63:0] wbuf [0:15];
    logic [7:0]  mbuf [0:15];
    logic [63:0] rbuf [0:15];
    logic        rfix [0:15];
    logic        rbad [0:15];
    int          nchk = 0;
    int          nerr = 0;
    int          rdcnt = 0;
    int          wrcnt = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    ecc_mem_wrap u_ecc_mem_wrap (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_write  (cmd_write),
        .cmd_addr   (cmd_addr),
        .cmd_len    (cmd_len),
        .wd_valid   (wd_valid),
        .wd_ready   (wd_ready),
        .wd_data    (wd_data),
        .wd_mask    (wd_mask),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .rsp_fixed  (rsp_fixed),
        .rsp_bad    (rsp_bad),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .err_sticky (err_sticky),
        .err_addr   (err_addr)
    );

    // Memory model: one-cycle read latency, counts accesses.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                mem[mem_addr[5:0]] <= mem_wdata;
                wrcnt <= wrcnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr[5:0]];
                rdcnt <= rdcnt + 1;
            end
        end
    end

    function automatic logic [63:0] merge_q(input logic [63:0] o, input logic [63:0] n,
                                            input logic [7:0] m);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[8*b +: 8] = m[b] ? n[8*b +: 8] : o[8*b +: 8];
        return r;
    endfunction

    task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic wr, input int a, input int n);
        cmd_valid = 1'b1;
        cmd_write = wr;
        cmd_addr  = AW'(a);
        cmd_len   = LW'(n - 1);
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_write(input int a, input int n);
        send_cmd(1'b1, a, n);
        chk("R11 cmd_ready low in write", 72'(cmd_ready), 72'd0);
        for (int i = 0; i < n; i++) begin
            wd_valid = 1'b1;
            wd_data  = wbuf[i];
            wd_mask  = mbuf[i];
            while (!wd_ready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
        end
        wd_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_read(input int a, input int n);
        send_cmd(1'b0, a, n);
        chk("R4 no rsp at first cycle", 72'(rsp_valid), 72'd0);
        chk("R11 wd_ready low in read", 72'(wd_ready), 72'd0);
        @(negedge clk);
        chk("R4 no rsp at second cycle", 72'(rsp_valid), 72'd0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R4 rsp beat on time", 72'(rsp_valid), 72'd1);
            rbuf[i] = rsp_data;
            rfix[i] = rsp_fixed;
            rbad[i] = rsp_bad;
        end
        @(negedge clk);
        chk("R5 no extra beat", 72'(rsp_valid), 72'd0);
    endtask

    task automatic write_one(input int a, input logic [63:0] d, input logic [7:0] m);
        wbuf[0] = d;
        mbuf[0] = m;
        do_write(a, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL R4 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int r0;
        int w0;
        logic [71:0] raw;
        logic [63:0] d;
        for (int i = 0; i < 64; i++) mem[i] = '0;

        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 cmd_ready", 72'(cmd_ready), 72'd1);
        chk("R10 wd_ready", 72'(wd_ready), 72'd0);
        chk("R10 rsp_valid", 72'(rsp_valid), 72'd0);
        chk("R10 mem_en", 72'(mem_en), 72'd0);
        chk("R10 err_sticky", 72'(err_sticky), 72'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 round trip, R6 full mask, R7 partial merge
        for (int v = 0; v < 6; v++) begin
            write_one(int'(VEC[v].addr), VEC[v].old_q, 8'hFF);
            r0 = rdcnt;
            w0 = wrcnt;
            write_one(int'(VEC[v].addr), VEC[v].new_q, VEC[v].mask);
            chk(VEC[v].mask == 8'hFF ? "R6 no read for full mask" : "R7 one read for partial mask",
                72'(rdcnt - r0), (VEC[v].mask == 8'hFF) ? 72'd0 : 72'd1);
            chk("R7 one write per beat", 72'(wrcnt - w0), 72'd1);
            do_read(int'(VEC[v].addr), 1);
            chk("R7 merged data", 72'(rbuf[0]), 72'(merge_q(VEC[v].old_q, VEC[v].new_q, VEC[v].mask)));
            chk("R1 clean flags", {70'd0, rfix[0], rbad[0]}, 72'd0);
        end

        // R1: stored layout and even parity
        d = 64'h3141_5926_5358_9793;
        write_one(10, d, 8'hFF);
        chk("R1 data field", 72'(mem[10][63:0]), 72'(d));
        chk("R1 even parity", 72'(^mem[10]), 72'd0);

        // R2: single flips across data, Hamming and overall bits
        foreach (VEC[k]) begin
            int bitn;
            bitn = (k == 0) ? 0 : (k == 1) ? 37 : (k == 2) ? 63 : (k == 3) ? 64 : (k == 4) ? 70 : 71;
            mem[10][bitn] = ~mem[10][bitn];
            do_read(10, 1);
            chk("R2 corrected data", 72'(rbuf[0]), 72'(d));
            chk("R2 fixed flag", {70'd0, rfix[0], rbad[0]}, 72'd2);
            mem[10][bitn] = ~mem[10][bitn];
        end
        chk("R9 no sticky after single errors", 72'(err_sticky), 72'd0);

        // R7: old word corrected before merge
        write_one(11, 64'h0011_2233_4455_6677, 8'hFF);
        mem[11][5] = ~mem[11][5];
        write_one(11, 64'h0000_0000_0000_00EE, 8'h01);
        do_read(11, 1);
        chk("R7 merge with corrected old", 72'(rbuf[0]), 72'h0011_2233_4455_66EE);
        chk("R7 rewritten word clean", {70'd0, rfix[0], rbad[0]}, 72'd0);

        // R3: double error on read
        write_one(30, 64'h5555_AAAA_5555_AAAA, 8'hFF);
        mem[30][2] = ~mem[30][2];
        mem[30][50] = ~mem[30][50];
        do_read(30, 1);
        chk("R3 bad flag", {70'd0, rfix[0], rbad[0]}, 72'd1);
        chk("R3 sticky set", 72'(err_sticky), 72'd1);
        chk("R3 error address", 72'(err_addr), 72'd30);

        // R8: uncorrectable old word aborts the merge write
        write_one(20, 64'h1234_1234_1234_1234, 8'hFF);
        mem[20][3] = ~mem[20][3];
        mem[20][40] = ~mem[20][40];
        raw = mem[20];
        w0 = wrcnt;
        write_one(20, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0F);
        chk("R8 memory unchanged", mem[20], raw);
        chk("R8 no write issued", 72'(wrcnt - w0), 72'd0);
        chk("R9 sticky remains", 72'(err_sticky), 72'd1);
        chk("R9 latest error address", 72'(err_addr), 72'd20);

        // R6: full-mask write over a bad word needs no read
        r0 = rdcnt;
        write_one(20, 64'hCAFE_0000_BABE_1111, 8'hFF);
        chk("R6 no read on full write", 72'(rdcnt - r0), 72'd0);
        do_read(20, 1);
        chk("R6 fresh data", 72'(rbuf[0]), 72'hCAFE_0000_BABE_1111);
        chk("R6 fresh flags", {70'd0, rfix[0], rbad[0]}, 72'd0);

        // R5: 16-beat burst, addresses increment
        for (int i = 0; i < 16; i++) begin
            wbuf[i] = {8{8'(i * 17)}} ^ 64'hA5A5_0F0F_5A5A_F0F0;
            mbuf[i] = 8'hFF;
        end
        r0 = rdcnt;
        w0 = wrcnt;
        do_write(40, 16);
        chk("R5 sixteen writes", 72'(wrcnt - w0), 72'd16);
        chk("R6 no reads in full burst", 72'(rdcnt - r0), 72'd0);
        for (int i = 0; i < 16; i++) chk("R5 burst address", 72'(mem[40 + i][63:0]), 72'(wbuf[i]));
        do_read(40, 16);
        for (int i = 0; i < 16; i++) chk("R5 burst read data", 72'(rbuf[i]), 72'(wbuf[i]));
        do_read(45, 3);
        for (int i = 0; i < 3; i++) chk("R5 offset burst", 72'(rbuf[i]), 72'(wbuf[5 + i]));

        // R7: partial beats inside a mixed burst
        for (int i = 0; i < 4; i++) begin
            wbuf[i] = 64'h1000_2000_3000_4000 + 64'(i);
            mbuf[i] = 8'hFF;
        end
        do_write(50, 4);
        for (int i = 0; i < 4; i++) wbuf[i] = 64'hEEEE_DDDD_CCCC_BBBB ^ 64'(i);
        mbuf[0] = 8'hFF; mbuf[1] = 8'h0F; mbuf[2] = 8'hFF; mbuf[3] = 8'hC3;
        r0 = rdcnt;
        do_write(50, 4);
        chk("R7 reads in mixed burst", 72'(rdcnt - r0), 72'd2);
        do_read(50, 4);
        for (int i = 0; i < 4; i++)
            chk("R7 mixed burst data", 72'(rbuf[i]),
                72'(merge_q(64'h1000_2000_3000_4000 + 64'(i), 64'hEEEE_DDDD_CCCC_BBBB ^ 64'(i), mbuf[i])));

        // R10: reset clears the sticky flag
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 sticky cleared", 72'(err_sticky), 72'd0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule